// File: doc/BRIEF.md
# Periodic Wakeup Downcounter

This block produces a periodic wakeup event in a slow real-time clock domain. It runs on the 32768 Hz clock and receives a one-cycle seconds strobe from the calendar prescaler. A source field selects where its ticks come from. A 16-bit reload value sets how many ticks make one period. Each time a period completes, the block sets a sticky wakeup flag and reloads itself. The flag, gated by an interrupt enable, drives the interrupt output.

Firmware programs the block through a plain write strobe and a combinational read port. The source and reload fields are protected. They can be changed only while the timer is stopped and a status bit reports that writing is allowed. Any write to them at another time is dropped.

Top module: `wkt_top`

## Requirements
- R1: With the run bit set, source code 000 ticks every 16 clock cycles, 001 every 8, 010 every 4 and 011 every 2. Ticks are aligned to the enabling write, so the first tick is consumed N cycles after the enabling edge.
- R2: Source codes 100 and 101 take one tick for every clock cycle in which the seconds strobe is high while the timer runs.
- R3: Source codes 110 and 111 also tick from the seconds strobe, and the period becomes reload + 65536 + 1 ticks.
- R4: The counter loads its period on the enabling edge. The wakeup flag (status bit 1) is set on the edge that consumes tick number reload+1 (plus 65536 under R3), and every following period is the same length with no software action.
- R5: The write-allowed status bit (status bit 0) is 1 after reset. It goes to 0 on the same edge at which the run bit becomes 1. After the run bit is cleared, it reads 0 after that edge and 1 after the next edge.
- R6: A write to the reload register, or to the control source field, is ignored while write-allowed is 0. The run and interrupt-enable bits in the same control write still take effect.
- R7: The interrupt output is high exactly when the wakeup flag and the interrupt-enable bit (control bit 1) are both 1.
- R8: Writing 0 to status bit 1 clears the wakeup flag, and writing 1 there has no effect. If a wakeup and a clearing write fall on the same edge, the flag ends up set.
- R9: Register map: address 0 is control (bit 0 run, bit 1 interrupt enable, bits 4:2 source), address 1 is reload [15:0], address 2 is status, and address 3 reads 0. After reset, control reads 0, reload reads 0xFFFF, status reads 1 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | 32768 Hz real-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick_i | input | 1 | One-cycle 1 Hz strobe from the calendar prescaler |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 16 | Read data, combinational from the addressed register |
| irq_o | output | 1 | Wakeup interrupt request |

## Verification
If the count is corrupted, the interval to the first wakeup flag changes. That shows within a single period, measured in edges from the enabling write, so each tick source is timed exactly against its divider. A prescaler phase error moves the flag by up to one divider period. A broken write guard shows as soon as the protected register is read back after a blocked write. A settle sequence that is wrong shows on the status bit within two edges of the run bit changing.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_STAT   = 2'd2,
    REG_SPARE  = 2'd3
  } wkt_reg_e;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned CTRL_SEL_LSB  = 2;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned STAT_WROK_BIT = 0;
  localparam int unsigned STAT_FLAG_BIT = 1;

  typedef logic [SEL_W-1:0] wkt_sel_t;

endpackage

// File: rtl/wkt_prescale.sv
module wkt_prescale
  import wkt_pkg::*;
#(
  parameter int unsigned PRE_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     sec_tick,
  input  wkt_sel_t sel,
  output logic     tick
);

  localparam int unsigned IDX_W = (PRE_W > 1) ? $clog2(PRE_W) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] div_hit;
  logic [IDX_W-1:0] div_idx;

  // div_hit[k] fires once every 2^(k+1) cycles, measured from the enabling edge
  for (genvar gi = 0; gi < PRE_W; gi++) begin : g_div
    assign div_hit[gi] = &pre_q[gi:0];
  end

  always_comb begin
    div_idx = IDX_W'(PRE_W - 1) - IDX_W'(sel[1:0]);
    tick    = run & (sel[2] ? sec_tick : div_hit[div_idx]);
  end

  always_comb begin
    if (run) pre_d = pre_q + 1'b1;
    else     pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R1: the fastest divided source never ticks on two cycles in a row
  p_div2_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel[2] && sel[1:0] == 2'b11 && tick) |=> !tick);

endmodule

// File: rtl/wkt_count.sv
module wkt_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic             ext,
  input  logic [CNT_W-1:0] reload,
  output logic             wake
);

  localparam int unsigned FULL_W = CNT_W + 1;

  logic [FULL_W-1:0] cnt_q, cnt_d, eff;
  logic              cnt_en;
  logic              at_zero;

  always_comb begin
    eff     = {ext, reload};
    at_zero = (cnt_q == '0);
    wake    = run & tick & at_zero;
    cnt_en  = start | (run & tick);
    if (start || at_zero) cnt_d = eff;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_d_hold: cnt_q <= cnt_d;
  end

  // R3: while running, the count never exceeds the (possibly extended) period
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= eff));

  // R4: the count moves only on ticks of the selected source
  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              wake,
  output logic              run,
  output logic              start,
  output logic              ie,
  output wkt_sel_t          sel,
  output logic              ext_d,
  output logic [CNT_W-1:0]  reload_d,
  output logic              flag,
  output logic              wr_ok
);

  localparam int unsigned SETTLE = 2;

  logic              run_q, run_d;
  logic              ie_q, ie_d;
  wkt_sel_t          sel_q, sel_d;
  logic [CNT_W-1:0]  reload_q;
  logic              flag_q, flag_d, flag_en;
  logic [SETTLE-1:0] idle_q, idle_d;
  logic              wr_ctrl, wr_rel, wr_stat, clr_req;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    wr_rel  = wr_en && (wr_addr == REG_RELOAD);
    wr_stat = wr_en && (wr_addr == REG_STAT);
    clr_req = wr_stat && !wr_data[STAT_FLAG_BIT];

    run_d    = wr_ctrl ? wr_data[CTRL_RUN_BIT] : run_q;
    ie_d     = wr_ctrl ? wr_data[CTRL_IE_BIT]  : ie_q;
    sel_d    = (wr_ctrl && wr_ok) ? wr_data[CTRL_SEL_LSB +: SEL_W] : sel_q;
    reload_d = (wr_rel  && wr_ok) ? wr_data : reload_q;
    ext_d    = sel_d[2] & sel_d[1];
    start    = wr_ctrl && wr_data[CTRL_RUN_BIT] && !run_q;

    // settle chain: cleared with the run bit, refilled one stage per edge
    if (run_d) idle_d = '0;
    else       idle_d = {idle_q[SETTLE-2:0], 1'b1};

    // hardware wakeup takes priority over a software clear
    flag_en = wake | clr_req;
    flag_d  = wake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ie_q     <= 1'b0;
      sel_q    <= '0;
      reload_q <= '1;
      idle_q   <= '1;
    end else begin
      run_q    <= run_d;
      ie_q     <= ie_d;
      sel_q    <= sel_d;
      reload_q <= reload_d;
      idle_q   <= idle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_comb begin
    run   = run_q;
    ie    = ie_q;
    sel   = sel_q;
    flag  = flag_q;
    wr_ok = idle_q[SETTLE-1];
  end

  always_comb begin
    rd_data = '0;
    case (wkt_reg_e'(rd_addr))
      REG_CTRL: begin
        rd_data[CTRL_RUN_BIT]                = run_q;
        rd_data[CTRL_IE_BIT]                 = ie_q;
        rd_data[CTRL_SEL_LSB +: SEL_W]       = sel_q;
      end
      REG_RELOAD: rd_data = reload_q;
      REG_STAT: begin
        rd_data[STAT_WROK_BIT] = wr_ok;
        rd_data[STAT_FLAG_BIT] = flag_q;
      end
      default: rd_data = '0;
    endcase
  end

  // R5: writing is never reported as allowed while running
  p_wrok_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !wr_ok);

  // R5: one edge after the run bit drops, writing becomes allowed
  p_wrok_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |=> (wr_ok || run_q));

  // R6: protected fields hold while writing is not allowed
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> ($stable(reload_q) && $stable(sel_q)));

  // R8: the flag stays set unless software writes 0 to it
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_stat && !wr_data[STAT_FLAG_BIT])) |=> flag_q);

endmodule

// File: rtl/wkt_top.sv
module wkt_top
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 4
) (
  input  logic              clk_rtc,
  input  logic              rst_n,
  input  logic              sec_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              irq_o
);

  localparam int unsigned RS_DEPTH = 2;

  logic [RS_DEPTH-1:0] rs_q;
  logic                rst_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_rtc or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RS_DEPTH-2:0], 1'b1};
  end
  assign rst_s = rs_q[RS_DEPTH-1];

  logic             run, start, ie, ext_d, flag, wr_ok, tick, wake;
  wkt_sel_t         sel;
  logic [CNT_W-1:0] reload_d;

  wkt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk_rtc),
    .rst_n    (rst_s),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .wr_data  (wr_data_i),
    .rd_addr  (rd_addr_i),
    .rd_data  (rd_data_o),
    .wake     (wake),
    .run      (run),
    .start    (start),
    .ie       (ie),
    .sel      (sel),
    .ext_d    (ext_d),
    .reload_d (reload_d),
    .flag     (flag),
    .wr_ok    (wr_ok)
  );

  wkt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk_rtc),
    .rst_n    (rst_s),
    .run      (run),
    .sec_tick (sec_tick_i),
    .sel      (sel),
    .tick     (tick)
  );

  wkt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk_rtc),
    .rst_n  (rst_s),
    .start  (start),
    .run    (run),
    .tick   (tick),
    .ext    (ext_d),
    .reload (reload_d),
    .wake   (wake)
  );

  assign irq_o = flag & ie;

  // R4: a completed period is visible in the flag on the next cycle
  p_wake_flag_r4: assert property (@(posedge clk_rtc) disable iff (!rst_s)
    wake |=> flag);

  // R1: no tick reaches the counter while stopped
  p_no_tick_idle_r1: assert property (@(posedge clk_rtc) disable iff (!rst_s)
    !run |-> !wake);

endmodule

// File: tb/sim_wkt_top.sv
module sim_wkt_top;
  import wkt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] rd_data;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wkt_top u0 (
    .clk_rtc    (clk),
    .rst_n      (rst_n),
    .sec_tick_i (sec),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  // {source[2:0], hold strobe, reload[15:0], expected edges to flag[19:0]}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {3'd3, 1'b0, 16'd4, 20'd10},
    {3'd2, 1'b0, 16'd2, 20'd12},
    {3'd1, 1'b0, 16'd1, 20'd16},
    {3'd0, 1'b0, 16'd0, 20'd16},
    {3'd0, 1'b0, 16'd2, 20'd48},
    {3'd4, 1'b1, 16'd2, 20'd3},
    {3'd5, 1'b1, 16'd3, 20'd4},
    {3'd6, 1'b1, 16'd0, 20'd65537}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_flag(int lim, output int n);
    n = 0;
    rd_addr = REG_STAT;
    while (n < lim) begin
      @(posedge clk);
      #1 n++;
      if (rd_data[STAT_FLAG_BIT]) break;
    end
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec = 1'b1;
    @(negedge clk); sec = 1'b0;
    rd_addr = REG_STAT;
    #1;
  endtask

  task automatic stop_and_settle();
    wr(REG_CTRL, 16'h0000);
    repeat (2) @(posedge clk);
    #1 wr(REG_STAT, 16'h0000);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..R9 got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R9 reset state
    rd(REG_CTRL, v);   chk("R9 ctrl reset", v, 32'h0);
    rd(REG_RELOAD, v); chk("R9 reload reset", v, 32'hFFFF);
    rd(REG_STAT, v);   chk("R9 status reset", v, 32'h1);
    rd(REG_SPARE, v);  chk("R9 spare reads 0", v, 32'h0);
    chk("R9 irq reset", irq, 32'h0);

    // period table: R1, R2, R3 and R4
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  s;
      logic        hold;
      logic [15:0] r;
      int          e;
      s    = VEC[i][39:37];
      hold = VEC[i][36];
      r    = VEC[i][35:20];
      e    = int'(VEC[i][19:0]);
      tag  = s[2] ? (s[1] ? "R3 R4 period" : "R2 R4 period") : "R1 R4 period";
      stop_and_settle();
      wr(REG_RELOAD, r);
      sec = hold;
      wr(REG_CTRL, {11'd0, s, 1'b0, 1'b1});
      wait_flag(e + 8, n);
      sec = 1'b0;
      chk(tag, n, e);
    end

    // R5 and R6: guard and settle behaviour
    stop_and_settle();
    wr(REG_RELOAD, 16'd7);
    wr(REG_CTRL, 16'h000D);
    rd(REG_STAT, v);   chk("R5 wr_ok falls with run", v[0], 32'h0);
    wr(REG_RELOAD, 16'd5);
    rd(REG_RELOAD, v); chk("R6 reload write ignored", v, 32'd7);
    wr(REG_CTRL, 16'h0001);
    rd(REG_CTRL, v);   chk("R6 source write ignored", v, 32'h000D);
    wr(REG_CTRL, 16'h0000);
    rd(REG_STAT, v);   chk("R5 wr_ok low one edge after stop", v[0], 32'h0);
    @(posedge clk); #1;
    rd(REG_STAT, v);   chk("R5 wr_ok high two edges after stop", v[0], 32'h1);
    rd(REG_CTRL, v);   chk("R6 source kept on stop write", v, 32'h000C);

    // R2: sparse seconds strobes
    wr(REG_STAT, 16'h0000);
    wr(REG_RELOAD, 16'd1);
    wr(REG_CTRL, 16'h0011);
    repeat (5) @(posedge clk);
    pulse_sec();
    chk("R2 no flag after first strobe", rd_data[STAT_FLAG_BIT], 32'h0);
    repeat (5) @(posedge clk);
    pulse_sec();
    chk("R2 flag after second strobe", rd_data[STAT_FLAG_BIT], 32'h1);

    // R7 interrupt gating
    chk("R7 irq masked", irq, 32'h0);
    wr(REG_CTRL, 16'h0013);
    chk("R7 irq asserted", irq, 32'h1);

    // R8 clearing
    wr(REG_STAT, 16'h0002);
    rd(REG_STAT, v); chk("R8 writing 1 keeps flag", v[1], 32'h1);
    wr(REG_STAT, 16'h0000);
    rd(REG_STAT, v); chk("R8 writing 0 clears flag", v[1], 32'h0);
    chk("R7 irq drops with flag", irq, 32'h0);

    // R8 priority: wakeup and clear on the same edge
    pulse_sec();
    chk("R4 reload mid-period no flag", rd_data[STAT_FLAG_BIT], 32'h0);
    @(negedge clk);
    sec = 1'b1; wr_en = 1'b1; wr_addr = REG_STAT; wr_data = 16'h0000;
    @(posedge clk);
    #1 wr_en = 1'b0; sec = 1'b0;
    rd(REG_STAT, v); chk("R8 wakeup beats clear", v[1], 32'h1);

    // R4 auto-reload: second period needs no software action
    stop_and_settle();
    wr(REG_RELOAD, 16'd4);
    wr(REG_CTRL, 16'h000D);
    wait_flag(30, n);
    chk("R4 first period", n, 32'd10);
    wr(REG_STAT, 16'h0000);
    wait_flag(30, n);
    chk("R4 second period after clear", n, 32'd9);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule